// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Wakeup Logic

This block gathers the one-cycle event pulses produced by a real-time clock core and turns them into an interrupt request and a deep-sleep wakeup signal. Six event sources are supported by default. Four are calendar interval ticks (second, minute, hour, day), one is an alarm match and one is a write-complete indication. The core also supplies a live write-pending level. Each event is recorded in a sticky status register that software reads and clears through a small register bus. A separate enable register decides which recorded events raise the interrupt.

While the chip is in deep sleep, the status register is held at zero. If an enabled interval event fires on a 1 Hz tick during that time, the block raises a wakeup output towards the power controller. It also remembers which events caused the wakeup. Once deep sleep has ended and the system clock is reported running again, those events are posted into the status register, and the interrupt follows.

Top module: `rtc_irq_wake`

## Requirements
- R1: Each event pulse `ev_pulse[i]` (bit map: 0 second, 1 minute, 2 hour, 3 day, 4 alarm, 5 write-complete) sets status bit i on the next clock edge. The bit stays set until cleared, whatever the enable register holds.
- R2: A bus write to address 0 clears every status bit whose data bit is 1 and leaves the bits written with 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: Status read bit 6 shows the live `wr_pend` input (zero during deep sleep). Writes to bit 6 have no effect on it.
- R4: After reset, the status and enable registers read zero and both `irq` and `wake` are low.
- R5: While `deep_sleep` is high, status bits 5..0 are forced to zero and event pulses do not set them.
- R6: Address 1 holds the 6-bit enable register. A write stores data bits 5..0, and a read returns them with bit 6 reading zero.
- R7: `irq` is high one cycle after any status bit is both set and enabled. It drops one cycle after the last such bit is cleared.
- R8: Writing zero to the enable register makes `irq` low one cycle after the write takes effect.
- R9: During deep sleep, a cycle with `tick_1hz` high and an enabled interval event (bits 0..3) sets `wake` on the next edge. A tick without an enabled interval event does not. `wake` then stays high until `deep_sleep` falls, and clears on the following edge.
- R10: The events that raised `wake` are posted into the status register on the first edge that sees `deep_sleep` low and `sclk_run` high, and `irq` follows one cycle later. While `sclk_run` stays low, they are not posted and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 6 | One-cycle event pulses from the clock core |
| tick_1hz | input | 1 | Marks the cycle of a 1 Hz tick |
| wr_pend | input | 1 | Live write-pending level |
| deep_sleep | input | 1 | High while the chip is in deep sleep |
| sclk_run | input | 1 | High while the system clock is running |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 status, 1 enable |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data for the addressed register |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Deep-sleep wakeup request |

## Verification
The hardest case to reach is the chain of wakeup and delayed interrupt. A tick must carry an enabled interval event while deep sleep is active. Deep sleep must then end while the system clock is still reported stopped, and the interrupt must stay low through that window. The bench steers this directly: it sets the enable register, enters deep sleep, applies a tick with a disabled event and then with an enabled one, and releases deep sleep before raising the clock-running input. Random phases then toggle deep sleep and the clock-running input at a low rate alongside random events and writes, so the same path is met again in mixed orders.

// File: rtl/rtc_irq_wake.sv
module rtc_irq_wake #(
  parameter int NUM_EV = 6,
  parameter logic [NUM_EV-1:0] IVL_MASK = 6'b001111,
  localparam int DW = NUM_EV + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic              tick_1hz,
  input  logic              wr_pend,
  input  logic              deep_sleep,
  input  logic              sclk_run,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic [NUM_EV-1:0] sts_q, en_q, held_q;
  logic              irq_q, wake_q;

  wire               wr_sts = bus_we && !bus_addr;
  wire               wr_en  = bus_we && bus_addr;
  wire [NUM_EV-1:0]  clr    = wr_sts ? bus_wdata[NUM_EV-1:0] : '0;
  wire [NUM_EV-1:0]  fire   = tick_1hz ? (ev_pulse & en_q & IVL_MASK) : '0;
  wire               post   = !deep_sleep && sclk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      held_q <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q <= |(sts_q & en_q);
      if (wr_en) en_q <= bus_wdata[NUM_EV-1:0];
      if (deep_sleep) begin
        sts_q  <= '0;
        held_q <= held_q | fire;
        wake_q <= wake_q | (|fire);
      end else begin
        sts_q  <= (sts_q & ~clr) | ev_pulse | (post ? held_q : '0);
        if (post) held_q <= '0;
        wake_q <= 1'b0;
      end
    end
  end

  assign bus_rdata = bus_addr ? {1'b0, en_q} : {wr_pend && !deep_sleep, sts_q};
  assign irq  = irq_q;
  assign wake = wake_q;
endmodule

module rtc_irq_wake_chk #(
  parameter int NUM_EV = 6,
  localparam int DW = NUM_EV + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EV-1:0] ev_pulse,
  input logic              wr_pend,
  input logic              deep_sleep,
  input logic              bus_we,
  input logic              bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq,
  input logic              wake,
  input logic [NUM_EV-1:0] sts_q,
  input logic [NUM_EV-1:0] en_q
);
  wire [NUM_EV-1:0] clr_w = (bus_we && !bus_addr) ? bus_wdata[NUM_EV-1:0] : '0;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !deep_sleep |=> ((($past(sts_q) & ~$past(clr_w)) & ~sts_q) == '0)); // R1
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep_sleep && |ev_pulse) |=> ((sts_q & $past(ev_pulse)) == $past(ev_pulse))); // R2
  AST_PEND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> (bus_rdata[NUM_EV] == (wr_pend && !deep_sleep))); // R3
  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |=> (sts_q == '0)); // R5
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq); // R8
  AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && deep_sleep) |=> wake); // R9
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !deep_sleep |=> !wake); // R9
endmodule

bind rtc_irq_wake rtc_irq_wake_chk #(.NUM_EV(NUM_EV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .wr_pend(wr_pend),
  .deep_sleep(deep_sleep), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake),
  .sts_q(sts_q), .en_q(en_q)
);

// File: tb/rtc_irq_wake_bench.sv
module rtc_irq_wake_bench;
  localparam logic [5:0] IVL = 6'b001111;
  logic       clk = 0, rst_n = 0;
  logic [5:0] ev = 0;
  logic       tick = 0, wr_pend = 0, ds = 0, sclk = 1, we = 0, addr = 0;
  logic [6:0] wdata = 0, rdata;
  logic       irq, wake;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 0;

  logic [5:0] sts_m = 0, en_m = 0, held_m = 0;
  logic       irq_m = 0, wake_m = 0;

  rtc_irq_wake u_rtc_irq_wake (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev), .tick_1hz(tick), .wr_pend(wr_pend),
    .deep_sleep(ds), .sclk_run(sclk), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .wake(wake)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected fewer", cyc);
      finish_run();
    end
  end

  function automatic logic [5:0] clr_of(logic w, logic a, logic [6:0] d);
    return (w && !a) ? d[5:0] : 6'h0;
  endfunction

  // model update for one clock edge, from the inputs applied during the cycle
  task automatic model_edge();
    logic [5:0] fire = tick ? (ev & en_m & IVL) : 6'h0;
    logic [5:0] c = clr_of(we, addr, wdata);
    irq_m = |(sts_m & en_m);
    if (we && addr) en_m = wdata[5:0];
    if (ds) begin
      sts_m = 0; held_m = held_m | fire; wake_m = wake_m | (|fire);
    end else begin
      sts_m = (sts_m & ~c) | ev | (sclk ? held_m : 6'h0);
      if (sclk) held_m = 0;
      wake_m = 0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ev = 0; tick = 0; we = 0;
  endtask

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic a, logic [6:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(logic a, logic [6:0] d);
    we = 1; addr = a; wdata = d; step();
  endtask

  function automatic logic [6:0] exp_sts();
    return {wr_pend && !ds, sts_m};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    // R4 reset state
    rd("R4 status", 0, 7'h00);
    rd("R4 enable", 1, 7'h00);
    chk("R4 irq", {6'b0, irq}, 7'h0);
    chk("R4 wake", {6'b0, wake}, 7'h0);
    rst_n = 1; step();

    // R1 sticky with enables off
    ev = 6'h10; step(); step(); step();
    rd("R1 alarm sticky", 0, 7'h10);
    chk("R1 no irq when disabled", {6'b0, irq}, 7'h0);
    ev = 6'h01; step();
    rd("R1 second latched", 0, 7'h11);

    // R2 write-0, write-1, set wins
    wr(0, 7'h00);
    rd("R2 write0 no effect", 0, 7'h11);
    wr(0, 7'h10);
    rd("R2 w1c alarm", 0, 7'h01);
    ev = 6'h01; we = 1; addr = 0; wdata = 7'h01; step();
    rd("R2 set beats clear", 0, 7'h01);
    wr(0, 7'h01);
    rd("R2 cleared", 0, 7'h00);

    // R3 read-only live pending bit
    wr_pend = 1; #1;
    rd("R3 pending shows", 0, 7'h40);
    wr(0, 7'h7f);
    rd("R3 write ignored", 0, 7'h40);
    wr_pend = 0; #1;
    rd("R3 pending falls", 0, 7'h00);

    // R6 enable register
    wr(1, 7'h7f);
    rd("R6 enable rw", 1, 7'h3f);
    wr(1, 7'h10);
    rd("R6 enable value", 1, 7'h10);

    // R7 irq timing
    ev = 6'h10; step();
    chk("R7 irq not yet", {6'b0, irq}, 7'h0);
    step();
    chk("R7 irq raised", {6'b0, irq}, 7'h1);
    ev = 6'h02; step();
    wr(0, 7'h10);
    chk("R7 irq one cycle late", {6'b0, irq}, 7'h1);
    step();
    chk("R7 irq dropped", {6'b0, irq}, 7'h0);
    rd("R7 minute stays", 0, 7'h02);

    // R8 enable to zero
    ev = 6'h10; step(); step();
    chk("R8 irq up", {6'b0, irq}, 7'h1);
    wr(1, 7'h00);
    step();
    chk("R8 irq down after enable zero", {6'b0, irq}, 7'h0);
    rd("R8 status kept", 0, 7'h12);

    // R5, R9, R10 deep sleep path
    wr(1, 7'h01);
    wr_pend = 1; ds = 1; step();
    rd("R5 status forced zero", 0, 7'h00);
    ev = 6'h10; step();
    rd("R5 event ignored asleep", 0, 7'h00);
    tick = 1; ev = 6'h02; step();
    chk("R9 disabled tick no wake", {6'b0, wake}, 7'h0);
    ev = 6'h01; step();
    chk("R9 no wake without tick", {6'b0, wake}, 7'h0);
    tick = 1; ev = 6'h01; step();
    chk("R9 wake raised", {6'b0, wake}, 7'h1);
    step(); step(); step();
    chk("R9 wake holds", {6'b0, wake}, 7'h1);
    sclk = 0; step();
    ds = 0; step();
    chk("R9 wake clears", {6'b0, wake}, 7'h0);
    rd("R10 not posted while clock stopped", 0, 7'h40);
    step(); step();
    chk("R10 irq held back", {6'b0, irq}, 7'h0);
    sclk = 1; step();
    rd("R10 posted", 0, 7'h41);
    chk("R10 irq not yet", {6'b0, irq}, 7'h0);
    step();
    chk("R10 irq after clock back", {6'b0, irq}, 7'h1);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      ev = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
      tick = ($urandom % 3 == 0);
      wr_pend = $urandom % 2;
      if ($urandom % 16 == 0) ds = ~ds;
      if ($urandom % 12 == 0) sclk = ~sclk;
      we = ($urandom % 4 == 0);
      addr = $urandom % 2;
      wdata = 7'($urandom);
      step();
      chk("R7 random irq", {6'b0, irq}, {6'b0, irq_m});
      chk("R9 random wake", {6'b0, wake}, {6'b0, wake_m});
      rd("R1 random status", 0, exp_sts());
      rd("R6 random enable", 1, {1'b0, en_m});
    end
    finish_run();
  end
endmodule